// File: doc/BRIEF.md
# Presence Sensor Power-Up and Configuration Sequencer

This block brings a passive infrared presence sensor from power-off to detection mode and checks that the sensor accepted its settings. When a setup request is taken, it latches the requested threshold, filter type and gain into a settings image. It then cuts the sensor supply for a fixed time and raises it again. Next it ignores the sensor's shared clock/output line for a blanking window, because that line ramps up slowly. After the blanking window it waits for the sensor's ready indication, which is two falling edges on the line.

Once the sensor is ready and a short settle time has passed, the block asks an external serial transfer engine to shift the whole image in. It then asks the engine to shift the image back out. It checks that both transfers finished within a configuration deadline and that the readback matches the image bit for bit. On success it releases both sensor lines, and the shared line becomes the detection output. Rising and falling edges on that line are then reported as one-cycle event pulses. Every change of setting goes through the full power cycle and rewrite again. All durations are parameters counted in clock cycles.

Top module: `pir_setup_seq`

## Requirements
- R1: After reset the block is idle: supply_en, busy, setup_done, pins_released, xfer_start and both event outputs are low, and err_code is 0.
- R2: A request is taken only when busy is low. From the clock edge that takes it, supply_en is low for exactly OFF_CYC cycles and then goes high. setup_done and err_code clear on that same edge.
- R3: Falling edges on line_in during the BLANK_CYC cycles that follow the supply rise are not counted toward readiness.
- R4: After the blanking window the block counts falling edges for up to RST_TMO_CYC cycles. The edge that counts the second falling edge starts a settle time of SETTLE_CYC cycles. After the settle time, xfer_start is high for one cycle with xfer_wr high.
- R5: If fewer than two falling edges arrive within that window, the block returns to idle with err_code = 1. supply_en stays high.
- R6: When xfer_done arrives for the write, the next cycle gives a one-cycle xfer_start with xfer_wr low, which requests the readback.
- R7: The settings image carries the threshold in bits 7:0, the gain code in bits 9:8 and the filter code in bits 12:10. All other bits are 0.
- R8: Filter selection values 0, 1, 2 and 3 encode as filter codes 7, 0, 1 and 2. Gain values 1, 2 and 3 encode as 1, 3 and 0, and a gain value of 0 is treated as gain 1.
- R9: The block counts the cycles from the write's xfer_start to the readback's xfer_done. If that count exceeds CFG_TMO_CYC, the block goes idle with err_code = 2. This check takes priority over the readback compare.
- R10: If xfer_rdata differs in any bit from the written image when the readback's xfer_done arrives, the block goes idle with err_code = 3 and does not enter detection mode.
- R11: On success, setup_done and pins_released go high and err_code stays 0. A change of level on line_in gives a one-cycle evt_rise or evt_fall pulse, which begins right after the second clock edge that sees the new level.
- R12: No event pulse is produced outside detection mode, including while the transfers are running.
- R13: setup_done and err_code hold until the next request is taken. A request made while busy is ignored. Settings inputs that change without a taken request do not change the image.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| setup_req | input | 1 | Request a full power cycle and configuration |
| thresh | input | THR_W | Requested detection threshold |
| filt_sel | input | 2 | Filter type selection (0..3) |
| gain_sel | input | 2 | Gain value (1..3, 0 taken as 1) |
| supply_en | output | 1 | Sensor supply enable |
| line_in | input | 1 | Shared clock/output line as seen by the block |
| xfer_start | output | 1 | One-cycle request to the transfer engine |
| xfer_wr | output | 1 | High: write the image; low: read it back |
| xfer_img | output | IMG_W | Settings image to write |
| xfer_done | input | 1 | Transfer engine finished the current transfer |
| xfer_rdata | input | IMG_W | Image read back from the sensor |
| busy | output | 1 | A setup sequence is in progress |
| setup_done | output | 1 | Last setup succeeded |
| err_code | output | 2 | 0 none, 1 ready timeout, 2 configuration late, 3 readback mismatch |
| pins_released | output | 1 | Detection mode: both sensor lines are inputs |
| evt_rise | output | 1 | Detection output rose |
| evt_fall | output | 1 | Detection output fell |

## Verification
A wrong phase count or a wrong phase order shows at the ports within one cycle. The supply edge, the busy level or the xfer_start pulse then lands on a different cycle from the one the reference expects. A falling edge that the blanking window should have hidden moves the write request earlier by several cycles. A wrong latch of the settings or a wrong field mapping shows in xfer_img at the write request. An off-by-one in the deadline count flips the result of the 29-cycle and 31-cycle configurations, so the error code differs when the readback completes. Events leaking outside detection mode appear on the event outputs two cycles after the line toggles.

// File: rtl/pir_setup_pkg.sv
package pir_setup_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_OFF, ST_BLANK, ST_WAIT, ST_SETTLE, ST_WRITE, ST_READ, ST_DETECT
  } seq_state_e;

  typedef enum logic [1:0] {
    ERR_NONE     = 2'd0,
    ERR_RDY_TMO  = 2'd1,
    ERR_LATE     = 2'd2,
    ERR_MISMATCH = 2'd3
  } seq_err_e;

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // filter type selection -> code sent to the sensor
  function automatic logic [2:0] filt_code(input logic [1:0] sel);
    case (sel)
      2'd0:    return 3'd7;
      2'd1:    return 3'd0;
      2'd2:    return 3'd1;
      default: return 3'd2;
    endcase
  endfunction

  // gain value -> code sent to the sensor (0 behaves as gain 1)
  function automatic logic [1:0] gain_code(input logic [1:0] g);
    case (g)
      2'd2:    return 2'd3;
      2'd3:    return 2'd0;
      default: return 2'd1;
    endcase
  endfunction

endpackage

// File: rtl/pir_cycle_timer.sv
module pir_cycle_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  output logic [W-1:0] cnt
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (clr)          cnt <= '0;
    else if (cnt != '1)    cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/pir_edge_sync.sv
module pir_edge_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise,
  output logic fall
);
  logic [2:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= '0;
    else        sh <= {sh[1:0], din};
  end

  // sh[1] is the synchronized level, sh[2] its previous value
  assign rise = sh[1] & ~sh[2];
  assign fall = ~sh[1] & sh[2];
endmodule

// File: rtl/pir_setup_seq.sv
module pir_setup_seq
  import pir_setup_pkg::*;
#(
  parameter int OFF_CYC     = 1750000,
  parameter int BLANK_CYC   = 100000,
  parameter int RST_TMO_CYC = 2500000,
  parameter int SETTLE_CYC  = 500,
  parameter int CFG_TMO_CYC = 1500000,
  parameter int THR_W       = 8,
  parameter int IMG_W       = 48
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             setup_req,
  input  logic [THR_W-1:0] thresh,
  input  logic [1:0]       filt_sel,
  input  logic [1:0]       gain_sel,
  output logic             supply_en,
  input  logic             line_in,
  output logic             xfer_start,
  output logic             xfer_wr,
  output logic [IMG_W-1:0] xfer_img,
  input  logic             xfer_done,
  input  logic [IMG_W-1:0] xfer_rdata,
  output logic             busy,
  output logic             setup_done,
  output logic [1:0]       err_code,
  output logic             pins_released,
  output logic             evt_rise,
  output logic             evt_fall
);
  localparam int TMAX = max2(max2(max2(OFF_CYC, BLANK_CYC), max2(RST_TMO_CYC, SETTLE_CYC)), CFG_TMO_CYC);
  localparam int TW   = $clog2(TMAX + 2);

  function automatic logic [IMG_W-1:0] pack_image(input logic [THR_W-1:0] thr,
                                                  input logic [1:0] fs,
                                                  input logic [1:0] gs);
    logic [IMG_W-1:0] v;
    v = '0;
    v[THR_W-1:0]     = thr;
    v[THR_W +: 2]    = gain_code(gs);
    v[THR_W+2 +: 3]  = filt_code(fs);
    return v;
  endfunction

  seq_state_e       st, st_n;
  logic [TW-1:0]    ph_cnt, cfg_cnt;
  logic [IMG_W-1:0] img_q;
  logic             fall_seen, pwr_q, done_q;
  seq_err_e         err_q;

  // named internal events
  logic line_rise, line_fall;
  logic req_take, rdy_hit, rdy_tmo, read_fin, xfer_late, img_bad;
  logic ph_clr, cfg_clr;

  pir_edge_sync u_sync (
    .clk(clk), .rst_n(rst_n), .din(line_in), .rise(line_rise), .fall(line_fall)
  );

  pir_cycle_timer #(.W(TW)) u_ph_tmr (
    .clk(clk), .rst_n(rst_n), .clr(ph_clr), .cnt(ph_cnt)
  );

  pir_cycle_timer #(.W(TW)) u_cfg_tmr (
    .clk(clk), .rst_n(rst_n), .clr(cfg_clr), .cnt(cfg_cnt)
  );

  assign req_take  = setup_req && (st == ST_IDLE || st == ST_DETECT);
  assign rdy_hit   = (st == ST_WAIT) && line_fall && fall_seen;
  assign rdy_tmo   = (st == ST_WAIT) && !rdy_hit && (ph_cnt == TW'(RST_TMO_CYC - 1));
  assign read_fin  = (st == ST_READ) && xfer_done;
  assign xfer_late = cfg_cnt > TW'(CFG_TMO_CYC);
  assign img_bad   = xfer_rdata != img_q;

  always_comb begin
    st_n = st;
    case (st)
      ST_IDLE, ST_DETECT: if (setup_req) st_n = ST_OFF;
      ST_OFF:    if (ph_cnt == TW'(OFF_CYC - 1))    st_n = ST_BLANK;
      ST_BLANK:  if (ph_cnt == TW'(BLANK_CYC - 1))  st_n = ST_WAIT;
      ST_WAIT:   if (rdy_hit) st_n = ST_SETTLE;
                 else if (rdy_tmo) st_n = ST_IDLE;
      ST_SETTLE: if (ph_cnt == TW'(SETTLE_CYC - 1)) st_n = ST_WRITE;
      ST_WRITE:  if (xfer_done) st_n = ST_READ;
      ST_READ:   if (xfer_done) st_n = (xfer_late || img_bad) ? ST_IDLE : ST_DETECT;
      default:   st_n = ST_IDLE;
    endcase
  end

  assign ph_clr  = st_n != st;
  assign cfg_clr = (st_n == ST_WRITE) && (st != ST_WRITE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      fall_seen <= 1'b0;
      pwr_q     <= 1'b0;
      img_q     <= '0;
      done_q    <= 1'b0;
      err_q     <= ERR_NONE;
    end else begin
      st <= st_n;
      if (st != ST_WAIT) fall_seen <= 1'b0;
      else if (line_fall) fall_seen <= 1'b1;
      if (req_take) pwr_q <= 1'b0;
      else if (st == ST_OFF && st_n == ST_BLANK) pwr_q <= 1'b1;
      if (req_take) begin
        img_q  <= pack_image(thresh, filt_sel, gain_sel);
        done_q <= 1'b0;
        err_q  <= ERR_NONE;
      end else if (rdy_tmo) begin
        err_q <= ERR_RDY_TMO;
      end else if (read_fin) begin
        if (xfer_late)    err_q  <= ERR_LATE;
        else if (img_bad) err_q  <= ERR_MISMATCH;
        else              done_q <= 1'b1;
      end
    end
  end

  assign supply_en     = pwr_q;
  assign xfer_start    = (st == ST_WRITE || st == ST_READ) && (ph_cnt == '0);
  assign xfer_wr       = st == ST_WRITE;
  assign xfer_img      = img_q;
  assign busy          = !(st == ST_IDLE || st == ST_DETECT);
  assign setup_done    = done_q;
  assign err_code      = err_q;
  assign pins_released = st == ST_DETECT;
  assign evt_rise      = line_rise && (st == ST_DETECT);
  assign evt_fall      = line_fall && (st == ST_DETECT);
endmodule

// File: rtl/pir_setup_seq_chk.sv
module pir_setup_seq_chk #(
  parameter int IMG_W = 48
) (
  input logic             clk,
  input logic             rst_n,
  input logic             setup_req,
  input logic             req_take,
  input logic             supply_en,
  input logic             xfer_start,
  input logic             xfer_done,
  input logic [IMG_W-1:0] xfer_rdata,
  input logic [IMG_W-1:0] xfer_img,
  input logic             busy,
  input logic             setup_done,
  input logic [1:0]       err_code,
  input logic             pins_released,
  input logic             evt_rise,
  input logic             evt_fall
);
  // R2
  supply_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(supply_en) |-> $past(req_take));

  // R4
  xfer_pwr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_start |-> (supply_en && busy));

  // R10
  detect_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pins_released) |-> ($past(xfer_done) && $past(xfer_rdata == xfer_img)));

  // R5
  err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_code != 2'd0) |-> (!setup_done && !pins_released));

  // R12
  evt_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_rise || evt_fall) |-> (pins_released && !busy));

  // R11
  evt_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({evt_rise, evt_fall}));

  // R13
  done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (setup_done && !req_take) |=> setup_done);

  // R13
  err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((err_code != 2'd0) && !req_take) |=> $stable(err_code));

  // R13
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && setup_req) |-> !req_take);
endmodule

bind pir_setup_seq pir_setup_seq_chk #(.IMG_W(IMG_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .setup_req(setup_req), .req_take(req_take),
  .supply_en(supply_en), .xfer_start(xfer_start), .xfer_done(xfer_done),
  .xfer_rdata(xfer_rdata), .xfer_img(xfer_img), .busy(busy),
  .setup_done(setup_done), .err_code(err_code), .pins_released(pins_released),
  .evt_rise(evt_rise), .evt_fall(evt_fall)
);

// File: tb/tb_pir_setup_seq.sv
module tb_pir_setup_seq;
  localparam int P_OFF = 20, P_BLANK = 12, P_RTMO = 40, P_SET = 5, P_CFG = 30;
  localparam int P_THR = 8, P_IMG = 16;

  logic clk = 0, rst_n = 0;
  logic setup_req = 0, line_in = 0, xfer_done = 0;
  logic [7:0] thresh = 0;
  logic [1:0] filt_sel = 0, gain_sel = 0;
  logic [P_IMG-1:0] xfer_rdata = 0;
  logic supply_en, xfer_start, xfer_wr, busy, setup_done, pins_released, evt_rise, evt_fall;
  logic [P_IMG-1:0] xfer_img;
  logic [1:0] err_code;

  pir_setup_seq #(.OFF_CYC(P_OFF), .BLANK_CYC(P_BLANK), .RST_TMO_CYC(P_RTMO),
                  .SETTLE_CYC(P_SET), .CFG_TMO_CYC(P_CFG), .THR_W(P_THR), .IMG_W(P_IMG)) dut (
    .clk(clk), .rst_n(rst_n), .setup_req(setup_req), .thresh(thresh), .filt_sel(filt_sel),
    .gain_sel(gain_sel), .supply_en(supply_en), .line_in(line_in), .xfer_start(xfer_start),
    .xfer_wr(xfer_wr), .xfer_img(xfer_img), .xfer_done(xfer_done), .xfer_rdata(xfer_rdata),
    .busy(busy), .setup_done(setup_done), .err_code(err_code), .pins_released(pins_released),
    .evt_rise(evt_rise), .evt_fall(evt_fall));

  always #10 clk = ~clk;

  int tests = 0, fails = 0, cycles = 0;
  bit finished = 0;
  int eng_lat = 3;
  logic [P_IMG-1:0] eng_flip = 0, req_img = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  // expected image, from the field layout and code tables
  function automatic logic [P_IMG-1:0] bench_img(input logic [7:0] t, input logic [1:0] f,
                                                 input logic [1:0] g);
    int fc, gc;
    case (f) 2'd0: fc = 7; 2'd1: fc = 0; 2'd2: fc = 1; default: fc = 2; endcase
    case (g) 2'd2: gc = 3; 2'd3: gc = 0; default: gc = 1; endcase
    return P_IMG'(t) | P_IMG'(gc * 256) | P_IMG'(fc * 1024);
  endfunction

  // ---------------- behavioural reference model ----------------
  // phases: 0 idle, 1 power off, 2 blank, 3 wait ready, 4 settle, 5 write, 6 read, 7 detect
  int ph = 0, tt = 0, cfg = 0, merr = 0;
  bit fseen = 0, mpwr = 0, mdone = 0;
  bit q1 = 0, q2 = 0, q3 = 0;
  logic [P_IMG-1:0] mimg = 0;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      chk(0, "WD", "watchdog expired", 0, 0);
      finish_run();
    end
    if (!rst_n) begin
      ph = 0; tt = 0; cfg = 0; merr = 0; fseen = 0; mpwr = 0; mdone = 0;
      q1 = 0; q2 = 0; q3 = 0; mimg = 0;
    end else begin
      int nph;
      bit fl;
      fl = !q2 && q3;
      nph = ph;
      case (ph)
        0, 7: if (setup_req) begin
          nph = 1; mpwr = 0; mdone = 0; merr = 0; mimg = bench_img(thresh, filt_sel, gain_sel);
        end
        1: if (tt == P_OFF - 1) begin nph = 2; mpwr = 1; end
        2: if (tt == P_BLANK - 1) nph = 3;
        3: if (fl && fseen) nph = 4;
           else if (tt == P_RTMO - 1) begin nph = 0; merr = 1; end
        4: if (tt == P_SET - 1) nph = 5;
        5: if (xfer_done) nph = 6;
        6: if (xfer_done) begin
             if (cfg > P_CFG) begin nph = 0; merr = 2; end
             else if (xfer_rdata != mimg) begin nph = 0; merr = 3; end
             else begin nph = 7; mdone = 1; end
           end
        default: nph = 0;
      endcase
      if (ph != 3) fseen = 0; else if (fl) fseen = 1;
      if (nph == 5 && ph != 5) cfg = 0; else cfg++;
      if (nph != ph) tt = 0; else tt++;
      ph = nph;
      q3 = q2; q2 = q1; q1 = line_in;
    end
  end

  always @(negedge clk) begin
    if (cycles >= 1 && !finished) begin
      bit eb, es, er, ef;
      eb = (ph >= 1 && ph <= 6);
      es = (ph == 5 || ph == 6) && tt == 0;
      er = (ph == 7) && q2 && !q3;
      ef = (ph == 7) && !q2 && q3;
      chk(supply_en == mpwr, "R2", "supply_en", 32'(supply_en), 32'(mpwr));
      chk(busy == eb, "R4", "busy", 32'(busy), 32'(eb));
      chk(xfer_start == es, "R4", "xfer_start", 32'(xfer_start), 32'(es));
      chk(xfer_wr == (ph == 5), "R6", "xfer_wr", 32'(xfer_wr), 32'(ph == 5));
      chk(setup_done == mdone, "R11", "setup_done", 32'(setup_done), 32'(mdone));
      chk(int'(err_code) == merr, "R9", "err_code", 32'(err_code), 32'(merr));
      chk(pins_released == (ph == 7), "R11", "pins_released", 32'(pins_released), 32'(ph == 7));
      chk(evt_rise == er, "R12", "evt_rise", 32'(evt_rise), 32'(er));
      chk(evt_fall == ef, "R12", "evt_fall", 32'(evt_fall), 32'(ef));
    end
  end

  // ---------------- transfer engine stand-in ----------------
  initial begin
    int cnt;
    bit is_rd;
    logic [P_IMG-1:0] mem;
    cnt = 0; is_rd = 0; mem = 0;
    forever begin
      @(posedge clk); #5;
      xfer_done = 0;
      if (cnt > 0) begin
        cnt--;
        if (cnt == 0) begin
          xfer_done = 1;
          xfer_rdata = is_rd ? (mem ^ eng_flip) : '0;
        end
      end else if (xfer_start) begin
        cnt = eng_lat;
        is_rd = !xfer_wr;
        if (xfer_wr) begin
          mem = xfer_img;
          chk(xfer_img == req_img, "R7", "image at write start", 32'(xfer_img), 32'(req_img));
        end
      end
    end
  end

  // ---------------- stimulus ----------------
  task automatic cyc();
    @(posedge clk); #5;
  endtask

  task automatic issue(input logic [7:0] t, input logic [1:0] f, input logic [1:0] g);
    cyc();
    thresh = t; filt_sel = f; gain_sel = g; setup_req = 1;
    req_img = bench_img(t, f, g);
    cyc();
    setup_req = 0;
  endtask

  // R3: two falling edges inside the blanking window
  task automatic blank_noise();
    repeat (P_OFF + 2) cyc();
    repeat (2) begin
      line_in = 1; cyc(); cyc();
      line_in = 0; cyc(); cyc();
    end
  endtask

  task automatic ready_falls(input int n);
    repeat (P_BLANK) cyc();
    repeat (n) begin
      line_in = 1; repeat (3) cyc();
      line_in = 0; repeat (3) cyc();
    end
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (!busy) break;
    end
  endtask

  task automatic run(input logic [7:0] t, input logic [1:0] f, input logic [1:0] g,
                     input int nf);
    issue(t, f, g);
    blank_noise();
    ready_falls(nf);
    wait_idle();
  endtask

  initial begin
    repeat (5) @(posedge clk);
    #5;
    @(negedge clk);
    chk(!supply_en && !busy && !setup_done && err_code == 0 && !pins_released,
        "R1", "reset state", {supply_en, busy, setup_done, pins_released}, 0);
    rst_n = 1;

    // success with blank-window noise, filter A gain 1
    eng_lat = 3;
    run(8'h5A, 2'd0, 2'd1, 2);
    chk(setup_done && err_code == 0, "R3", "setup completes despite blank falls", 32'(setup_done), 1);
    chk(pins_released, "R11", "released after success", 32'(pins_released), 1);
    cyc(); line_in = 1; repeat (4) cyc(); line_in = 0; repeat (4) cyc();

    // re-run from detection mode, other codes (R8)
    run(8'h33, 2'd1, 2'd2, 2);
    chk(setup_done, "R8", "filter 1 gain 2 success", 32'(setup_done), 1);
    run(8'hC4, 2'd2, 2'd3, 2);
    chk(setup_done, "R8", "filter 2 gain 3 success", 32'(setup_done), 1);
    run(8'h01, 2'd3, 2'd0, 2);
    chk(setup_done, "R8", "filter 3 gain 0 success", 32'(setup_done), 1);

    // ready timeout
    run(8'h10, 2'd0, 2'd1, 1);
    chk(err_code == 2'd1 && supply_en, "R5", "ready timeout", 32'(err_code), 1);

    // deadline boundary: 29 cycles ok, 31 late
    eng_lat = 14;
    run(8'h20, 2'd1, 2'd1, 2);
    chk(setup_done && err_code == 0, "R9", "29-cycle configuration accepted", 32'(err_code), 0);
    eng_lat = 15;
    run(8'h21, 2'd1, 2'd1, 2);
    chk(err_code == 2'd2, "R9", "31-cycle configuration late", 32'(err_code), 2);

    // late and mismatched together: late wins
    eng_flip = 16'h0004;
    run(8'h22, 2'd2, 2'd1, 2);
    chk(err_code == 2'd2, "R9", "late has priority over mismatch", 32'(err_code), 2);

    // mismatch
    eng_lat = 3; eng_flip = 16'h0400;
    run(8'h23, 2'd3, 2'd3, 2);
    chk(err_code == 2'd3 && !pins_released, "R10", "readback mismatch", 32'(err_code), 3);
    repeat (20) cyc();
    @(negedge clk);
    chk(err_code == 2'd3, "R13", "error holds without request", 32'(err_code), 3);
    eng_flip = 0;

    // request while busy ignored, settings change ignored, line toggles during write
    eng_lat = 10;
    issue(8'h77, 2'd2, 2'd2);
    repeat (3) cyc();
    thresh = 8'hFF; filt_sel = 2'd0; setup_req = 1;
    cyc();
    setup_req = 0;
    repeat (P_OFF + 2) cyc();
    ready_falls(2);
    for (int i = 0; i < 100; i++) begin
      if (xfer_start && xfer_wr) break;
      cyc();
    end
    line_in = 1; cyc(); cyc(); line_in = 0;
    wait_idle();
    chk(setup_done && xfer_img == bench_img(8'h77, 2'd2, 2'd2), "R13",
        "busy request and later inputs ignored", 32'(xfer_img), 32'(bench_img(8'h77, 2'd2, 2'd2)));
    cyc(); line_in = 1; repeat (3) cyc(); line_in = 0; repeat (3) cyc();

    finish_run();
  end
endmodule